// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds an operand into a running accumulator one bit per clock. It holds two shift registers of the same width, the accumulator and the addend, plus one full-adder cell and one carry flip-flop. Operands reach the block over a single serial data line, least significant bit first. A start pulse together with a two-bit operation code chooses one of three operations. Loading the accumulator or the addend shifts the serial line into that register for WIDTH clocks. Adding recirculates both registers through the adder cell for WIDTH clocks.

During an add, the adder cell takes the low bits of both registers and the stored carry on every clock. The sum bit re-enters the accumulator at its top. The addend shifts down and fills with zeros from the top. The new carry goes into the carry flip-flop. When an operation ends, a done flag rises for one cycle. The final carry stays visible until a clear. The carry is never zeroed by starting an add, so two adds in a row chain into a wider sum. A synchronous clear empties both registers and the carry, and stops any operation in progress.

Top module: `serial_acc_adder`

## Requirements
- R1: After reset, and one clock after `clr_i` is high, `acc_o` is 0, `carry_o` is 0 and `done_o` is 0. The addend register is also empty, and any operation in progress stops. `clr_i` takes priority over `start_i`.
- R2: A start with `op_i` = 2'b01 loads the accumulator. On each of the next WIDTH clocks, `ser_i` enters the accumulator's top bit while its contents move one place toward bit 0. After the operation, bit k of `acc_o` holds the k-th serial bit sent, counting from 0.
- R3: A start with `op_i` = 2'b10 loads the addend in the same way, WIDTH clocks, least significant bit first. `acc_o` and `carry_o` do not change during this load.
- R4: A start with `op_i` = 2'b11 performs an add over exactly WIDTH clocks. On each of those clocks, bit 0 of the accumulator, bit 0 of the addend and the stored carry are summed. The sum bit enters the accumulator's top bit, and the carry-out is stored. At the end, `acc_o` equals (A + B + carry_in) mod 2^WIDTH.
- R5: During an add, the addend shifts toward bit 0 and fills with zeros. A second add with no load in between therefore adds only the stored carry.
- R6: Every operation raises `done_o` for exactly one cycle. `done_o` goes high at the clock edge that performs the operation's last shift.
- R7: After an add, `carry_o` holds the carry out of the top bit. It holds this value until the next add or clear, and it serves as the carry-in of the next add.
- R8: A start pulse is ignored while an operation is in progress, including on its last shift clock. A start with `op_i` = 2'b00 is also ignored.
- R9: With WIDTH = 4, the following sequence leaves `acc_o` = 4'b1010 and `carry_o` = 0: clear, load addend 0111, add, load addend 0011, add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of registers, carry and control |
| start_i | input | 1 | Start pulse; operation taken from `op_i` |
| op_i | input | 2 | 01 load accumulator, 10 load addend, 11 add, 00 none |
| ser_i | input | 1 | Serial operand bit, least significant first |
| acc_o | output | WIDTH | Accumulator register contents |
| carry_o | output | 1 | Stored carry; final carry after an add |
| done_o | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The add is tried with several inputs, each aimed at a different kind of fault:
- The classic 0111 + 0011 case rules out sum-bit misplacement.
- An all-ones plus one case ripples the carry through every bit and ends with a carry-out.
- A back-to-back add with no reload proves that the addend drained to zeros and that the carry chains in.
- A varied sequence of loads and adds with mixed data and no clears between them exercises the general case.

Two further stimuli separate control faults from datapath faults: a start pulse in the middle of an operation, and a clear in the middle of an add. A reference model compares every cycle, so intermediate partial sums also reveal wrong shift direction or timing.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOAD_A = 2'b01,
    OP_LOAD_B = 2'b10,
    OP_ADD    = 2'b11
  } sa_op_e;
endpackage

// File: rtl/sa_fa.sv
module sa_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/sa_shreg.sv
module sa_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= '0;
    else if (shift_i) q_q <= {ser_i, q_q[WIDTH-1:1]};
  end

  assign q_o = q_q;

  // shifting moves old bit 1 into bit 0
  a_r2_shift_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i) |=> (q_o[0] == $past(q_o[1])) && (q_o[WIDTH-1] == $past(ser_i)));
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   start_i,
  input  sa_op_e op_i,
  output logic   busy_o,
  output sa_op_e op_o,
  output logic   last_o,
  output logic   done_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  sa_op_e        op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
    end else begin
      done_q <= busy_q && (cnt_q == LAST);
      if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i && op_i != OP_NONE) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        op_q   <= op_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign last_o = busy_q && (cnt_q == LAST);
  assign done_o = done_q;

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !clr_i) |=> (done_o && !busy_o));
  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i) |=> (op_o == $past(op_o)));
  a_r1_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!busy_o && !done_o));
endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder
  import sa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o,
  output logic             done_o
);
  logic             busy, last;
  sa_op_e           op;
  logic [WIDTH-1:0] a_q, b_q;
  logic             sum, cout, carry_q;
  logic             add_act, sh_a, sh_b, a_in, b_in;

  sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .start_i(start_i),
    .op_i   (sa_op_e'(op_i)),
    .busy_o (busy),
    .op_o   (op),
    .last_o (last),
    .done_o (done_o)
  );

  assign add_act = busy && (op == OP_ADD);
  assign sh_a    = busy && (op == OP_LOAD_A || op == OP_ADD);
  assign sh_b    = busy && (op == OP_LOAD_B || op == OP_ADD);
  assign a_in    = add_act ? sum : ser_i;
  assign b_in    = add_act ? 1'b0 : ser_i;  // addend drains to zero

  sa_shreg #(.WIDTH(WIDTH)) u_areg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .shift_i(sh_a), .ser_i(a_in), .q_o(a_q)
  );

  sa_shreg #(.WIDTH(WIDTH)) u_breg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .shift_i(sh_b), .ser_i(b_in), .q_o(b_q)
  );

  sa_fa u_fa (
    .a_i(a_q[0]), .b_i(b_q[0]), .c_i(carry_q),
    .s_o(sum), .c_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      carry_q <= 1'b0;
    else if (clr_i)   carry_q <= 1'b0;
    else if (add_act) carry_q <= cout;
  end

  assign acc_o   = a_q;
  assign carry_o = carry_q;

  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0 && carry_o == 1'b0 && b_q == '0));
  a_r5_addend_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_act && last && !clr_i) |=> (b_q == '0));
  a_r7_carry_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_act && !clr_i) |=> $stable(carry_o));
  a_r3_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sh_a && !clr_i) |=> $stable(acc_o));
endmodule

// File: tb/serial_acc_adder_tb.sv
module serial_acc_adder_tb;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0, start_i = 1'b0, ser_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] acc_o;
  logic         carry_o, done_o;

  int    checks = 0, errors = 0;
  bit    finished = 0;
  string ctx = "R1";

  // reference model state
  int m_a, m_b, m_c, m_cnt, m_op;
  bit m_busy, m_done;

  always #2.5 clk_i = ~clk_i;

  serial_acc_adder #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .start_i(start_i),
    .op_i(op_i), .ser_i(ser_i), .acc_o(acc_o), .carry_o(carry_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_a = 0; m_b = 0; m_c = 0; m_cnt = 0; m_op = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (clr_i) begin
        m_a = 0; m_b = 0; m_c = 0; m_cnt = 0; m_busy = 0;
      end else if (m_busy) begin
        if (m_op == 1) m_a = (m_a >> 1) | (int'(ser_i) << (W-1));
        else if (m_op == 2) m_b = (m_b >> 1) | (int'(ser_i) << (W-1));
        else begin
          int s;
          s = (m_a & 1) + (m_b & 1) + m_c;
          m_a = (m_a >> 1) | ((s & 1) << (W-1));
          m_b = m_b >> 1;
          m_c = s >> 1;
        end
        m_cnt++;
        if (m_cnt == W) begin m_busy = 0; m_done = 1; end
      end else if (start_i && op_i != 2'b00) begin
        m_busy = 1; m_cnt = 0; m_op = int'(op_i);
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni) begin
    chk(int'(acc_o) == m_a, {ctx, " acc"}, int'(acc_o), m_a);
    chk(int'(carry_o) == m_c, {ctx, " carry"}, int'(carry_o), m_c);
    chk(int'(done_o) == int'(m_done), {ctx, " done"}, int'(done_o), int'(m_done));
  end

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] d);
    @(negedge clk_i); start_i = 1'b1; op_i = op;
    @(negedge clk_i); start_i = 1'b0;
    for (int k = 0; k < W; k++) begin ser_i = d[k]; @(negedge clk_i); end
    ser_i = 1'b0;
    chk(done_o == 1'b1, "R6 done at end", int'(done_o), 1);
  endtask

  task automatic do_clear();
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
    chk(acc_o == '0 && carry_o == 1'b0, "R1 clear", int'(acc_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(acc_o == '0 && carry_o == 1'b0 && done_o == 1'b0, "R1 reset", int'(acc_o), 0);
    rst_ni = 1'b1;

    ctx = "R9"; do_clear();
    run_op(2'b10, 4'b0111);
    chk(acc_o == 4'b0000, "R3 acc untouched by addend load", int'(acc_o), 0);
    run_op(2'b11, 4'b0000);
    chk(acc_o == 4'b0111, "R4 first add", int'(acc_o), 7);
    run_op(2'b10, 4'b0011);
    run_op(2'b11, 4'b0000);
    chk(acc_o == 4'b1010 && carry_o == 1'b0, "R9 0111+0011", int'(acc_o), 10);

    ctx = "R7"; do_clear();
    run_op(2'b01, 4'b1111);
    chk(acc_o == 4'b1111, "R2 accumulator load", int'(acc_o), 15);
    run_op(2'b10, 4'b0001);
    run_op(2'b11, 4'b0000);
    chk(acc_o == 4'b0000 && carry_o == 1'b1, "R7 full ripple carry", int'(carry_o), 1);
    ctx = "R5";
    run_op(2'b11, 4'b0000);
    chk(acc_o == 4'b0001 && carry_o == 1'b0, "R5 drained addend plus carry", int'(acc_o), 1);

    ctx = "R8";
    @(negedge clk_i); start_i = 1'b1; op_i = 2'b00;
    @(negedge clk_i); start_i = 1'b0;
    repeat (W + 1) @(negedge clk_i);
    chk(acc_o == 4'b0001 && done_o == 1'b0, "R8 op 00 ignored", int'(acc_o), 1);
    // start pulses during a load, including on the last shift clock
    @(negedge clk_i); start_i = 1'b1; op_i = 2'b01;
    @(negedge clk_i); op_i = 2'b11; ser_i = 1'b0;
    for (int k = 0; k < W; k++) begin ser_i = k[0]; @(negedge clk_i); end
    start_i = 1'b0; ser_i = 1'b0;
    repeat (W + 2) @(negedge clk_i);
    chk(acc_o == 4'b1010 && done_o == 1'b0, "R8 mid-op start ignored", int'(acc_o), 10);

    ctx = "R1 abort";
    run_op(2'b10, 4'b0110);
    @(negedge clk_i); start_i = 1'b1; op_i = 2'b11;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i); clr_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0; start_i = 1'b0;
    repeat (W + 1) @(negedge clk_i);
    chk(acc_o == '0 && done_o == 1'b0, "R1 clear aborts add", int'(acc_o), 0);

    ctx = "R4";
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] x, y;
      x = W'(i * 5 + 3);
      y = W'(i * 7 + 1);
      run_op(2'b01, x);
      run_op(2'b10, y);
      run_op(2'b11, 4'b0000);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule